// File: doc/BRIEF.md
# Six-Channel Programmable Trigger Coincidence

This block turns six conditioned trigger channel levels into one trigger decision. The decision follows an arbitrary boolean function of the six channels, held as a 64-entry truth table. In each cycle the current channel levels form a 6-bit index, and that index selects one table bit as the raw trigger. The raw trigger is registered, and a single-cycle pulse marks each rising edge of the registered decision.

Software reduces its coincidence expression to a truth table. The expression may give each channel a required, vetoing or ignored role, and may mix AND and OR terms. Software then writes the table into a staging copy in 16-bit slices through a small write port. A write to a dedicated commit address copies the whole staging copy into the live table on one clock edge. Because of this, the lookup never sees a table that is half old and half new.

Top module: `coinc_lut_top`

## Requirements
- R1: One cycle after the channels are presented on `chIn`, `trigLevel` equals live-table bit number `chIn`. Bit 0 of `chIn` is channel 1 and bit 5 is channel 6, so for example index 6'b001010 means channels 2 and 4 are high.
- R2: After reset, the staging table and the live table are all zeros and `trigLevel` and `trigPulse` are 0. No trigger occurs for any channel pattern until a table is committed.
- R3: A write with `wrEn`=1 and `wrAddr` from 0 to 3 stores `wrData` into staging slice `wrAddr`, which covers table bits [16*wrAddr+15 : 16*wrAddr]. On its own, such a write leaves `trigLevel` unchanged.
- R4: A write with `wrEn`=1 and `wrAddr`=4 copies the full staging table into the live table at that clock edge. The lookup made on that same edge still uses the old table. The new table decides `trigLevel` from the following edge on.
- R5: Writes with `wrAddr` from 5 to 7 change neither the staging table nor the live table.
- R6: `trigPulse` is 1 for exactly the first cycle in which `trigLevel` is 1 after being 0.
- R7: While `trigLevel` stays 1, no further pulse is produced. A new pulse comes only after `trigLevel` has returned to 0 and risen again.
- R8: The staging table keeps its contents across a commit. Rewriting one slice and committing again changes only the 16 table entries of that slice.
- R9: Any six-input function can be realised. This includes a plain AND of two channels, a required channel combined with a vetoing channel, and an AND of such a pair with an OR over the remaining four channels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Table write strobe |
| wrAddr | input | 3 | 0-3 staging slice, 4 commit, 5-7 unused |
| wrData | input | 16 | Slice data for staging writes |
| chIn | input | 6 | Conditioned channel levels, bit 0 = channel 1 |
| trigLevel | output | 1 | Registered trigger decision |
| trigPulse | output | 1 | One-cycle pulse on rising edge of trigLevel |

## Verification
The hardest situation to reach from the ports is the commit boundary. There, the lookup on the commit edge must still use the old table while the next edge uses the new one. A staging write must also leave the live table alone, and an out-of-range address must not fold onto a real slice. The stimulus creates this boundary directly: it stages a full table of ones without committing, holds one channel pattern, and samples `trigLevel` in the cycle of the commit and in the cycle after it. It then writes to the unused addresses and probes one index in each slice, which exposes any aliasing. After that, several complete functions are loaded and all 64 channel patterns are swept, with the expected results computed from the boolean expressions.

// File: rtl/coinc_lut_pkg.sv
package coinc_lut_pkg;

  // Strobes from the write decoder to the table datapath
  typedef struct packed {
    logic stageWr;   // load one staging slice
    logic commit;    // copy staging table into live table
  } tblStrobe_t;

endpackage

// File: rtl/coinc_lut_ctrl.sv
module coinc_lut_ctrl
  import coinc_lut_pkg::*;
#(
  parameter int NUM_WORDS = 4
) (
  input  logic                          wrEn,
  input  logic [$clog2(NUM_WORDS+1)-1:0] wrAddr,
  output tblStrobe_t                    strobe,
  output logic [$clog2(NUM_WORDS)-1:0]  stageIdx
);

  localparam int ADDR_W = $clog2(NUM_WORDS + 1);
  localparam int IDX_W  = $clog2(NUM_WORDS);
  localparam logic [ADDR_W-1:0] COMMIT_ADDR = ADDR_W'(NUM_WORDS);

  always_comb begin
    strobe.stageWr = wrEn && (wrAddr < COMMIT_ADDR);
    strobe.commit  = wrEn && (wrAddr == COMMIT_ADDR);
    stageIdx       = wrAddr[IDX_W-1:0];
  end

endmodule

// File: rtl/coinc_lut_dp.sv
module coinc_lut_dp
  import coinc_lut_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int WORD_W = 16
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  tblStrobe_t                                 strobe,
  input  logic [$clog2((1 << NUM_CH) / WORD_W)-1:0]  stageIdx,
  input  logic [WORD_W-1:0]                          wrData,
  input  logic [NUM_CH-1:0]                          chIn,
  output logic                                       trigLevel,
  output logic                                       trigPulse
);

  localparam int TBL_BITS  = 1 << NUM_CH;
  localparam int NUM_WORDS = TBL_BITS / WORD_W;
  localparam int IDX_W     = $clog2(NUM_WORDS);

  logic [TBL_BITS-1:0]  stageTbl;
  logic [TBL_BITS-1:0]  activeTbl;
  logic [NUM_WORDS-1:0] wordWe;
  logic                 rawTrig;
  logic                 trigLevelDly;

  // Per-slice write enables
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_we
    assign wordWe[w] = strobe.stageWr && (stageIdx == IDX_W'(w));
  end

  // Staging table: slice-wise loads, kept across commits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageTbl <= '0;
    end else begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (wordWe[w]) stageTbl[w*WORD_W +: WORD_W] <= wrData;
      end
    end
  end

  // Live table: replaced as a whole on commit
  always_ff @(posedge clk) begin
    if (!rstN)              activeTbl <= '0;
    else if (strobe.commit) activeTbl <= stageTbl;
  end

  // Lookup and decision register
  assign rawTrig = activeTbl[chIn];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigLevel    <= 1'b0;
      trigLevelDly <= 1'b0;
    end else begin
      trigLevel    <= rawTrig;
      trigLevelDly <= trigLevel;
    end
  end

  assign trigPulse = trigLevel && !trigLevelDly;

  AST_LOOKUP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> trigLevel == $past(activeTbl[chIn])); // R1
  AST_ZERO_TABLE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (activeTbl == '0) |=> !trigLevel); // R2
  AST_LIVE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(activeTbl)); // R3
  AST_COMMIT_WHOLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> activeTbl == $past(stageTbl)); // R4
  AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> trigLevel && !$past(trigLevel)); // R6
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse); // R7

endmodule

// File: rtl/coinc_lut_top.sv
module coinc_lut_top
  import coinc_lut_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int WORD_W = 16
) (
  input  logic                                          clk,
  input  logic                                          rstN,
  input  logic                                          wrEn,
  input  logic [$clog2((1 << NUM_CH) / WORD_W + 1)-1:0] wrAddr,
  input  logic [WORD_W-1:0]                             wrData,
  input  logic [NUM_CH-1:0]                             chIn,
  output logic                                          trigLevel,
  output logic                                          trigPulse
);

  localparam int NUM_WORDS = (1 << NUM_CH) / WORD_W;
  localparam int IDX_W     = $clog2(NUM_WORDS);

  tblStrobe_t       strobe;
  logic [IDX_W-1:0] stageIdx;

  coinc_lut_ctrl #(
    .NUM_WORDS(NUM_WORDS)
  ) u_ctrl (
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .strobe  (strobe),
    .stageIdx(stageIdx)
  );

  coinc_lut_dp #(
    .NUM_CH(NUM_CH),
    .WORD_W(WORD_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .stageIdx (stageIdx),
    .wrData   (wrData),
    .chIn     (chIn),
    .trigLevel(trigLevel),
    .trigPulse(trigPulse)
  );

endmodule

// File: tb/coinc_lut_top_tb.sv
module coinc_lut_top_tb;

  localparam int NUM_FUNCS = 6;
  localparam int WATCHDOG  = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [5:0]  chIn = '0;
  logic        trigLevel;
  logic        trigPulse;

  int checks = 0;
  int failures = 0;
  int cycleCount = 0;

  always #10 clk = ~clk;  // 50 MHz

  coinc_lut_top u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .chIn(chIn), .trigLevel(trigLevel), .trigPulse(trigPulse)
  );

  // Reference boolean functions; channel n is idx[n-1]
  function automatic logic refEval(int f, logic [5:0] idx);
    logic c1, c2, c3, c4, c5, c6;
    {c6, c5, c4, c3, c2, c1} = idx;
    case (f)
      0:       return c2 & c4;                                // plain AND
      1:       return c1 & ~c2;                               // veto
      2:       return (c1 & ~c2) & (c3 | c4 | c5 | c6);       // mixed
      3:       return c1 | c6;                                // OR, rest ignored
      4:       return ~(c3 & c5);                             // NAND
      default: return c1 ^ c2 ^ c3 ^ c4 ^ c5 ^ c6;            // parity
    endcase
  endfunction

  function automatic logic [63:0] buildTbl(int f);
    logic [63:0] t;
    for (int i = 0; i < 64; i++) t[i] = refEval(f, 6'(i));
    return t;
  endfunction

  localparam logic [63:0] FUNC_TBL [NUM_FUNCS] = '{
    buildTbl(0), buildTbl(1), buildTbl(2), buildTbl(3), buildTbl(4), buildTbl(5)
  };

  task automatic checkVal(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, hold across one rising edge, release
  task automatic writeWord(logic [2:0] addr, logic [15:0] data);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic loadTable(logic [63:0] tbl);
    for (int w = 0; w < 4; w++) writeWord(3'(w), tbl[w*16 +: 16]);
    writeWord(3'd4, 16'h0);
  endtask

  task automatic probe(logic [5:0] idx);
    chIn = idx;
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount == WATCHDOG) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cycleCount, WATCHDOG);
      finishRun();
    end
  end

  initial begin
    logic prevExp;
    logic curExp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2: reset state and silence with an empty table
    checkVal("R2 level after reset", trigLevel, 0);
    checkVal("R2 pulse after reset", trigPulse, 0);
    probe(6'd63);
    checkVal("R2 empty table all-high", trigLevel, 0);
    probe(6'd0);
    checkVal("R2 empty table all-low", trigLevel, 0);

    // R3: staging writes alone do not reach the decision
    chIn = 6'd37;
    for (int w = 0; w < 4; w++) writeWord(3'(w), 16'hFFFF);
    checkVal("R3 staged but not committed", trigLevel, 0);

    // R4: commit edge still uses old table, next edge uses new
    writeWord(3'd4, 16'h0);
    checkVal("R4 commit-edge lookup old", trigLevel, 0);
    @(negedge clk);
    checkVal("R4 new table next edge", trigLevel, 1);
    checkVal("R6 pulse on rise", trigPulse, 1);
    @(negedge clk);
    checkVal("R7 level held", trigLevel, 1);
    checkVal("R7 no repeat pulse", trigPulse, 0);

    // R8: rewrite slice 2 only (index 37 lives there)
    writeWord(3'd2, 16'h0000);
    writeWord(3'd4, 16'h0);
    @(negedge clk);
    checkVal("R8 rewritten slice cleared", trigLevel, 0);
    checkVal("R6 no pulse on fall", trigPulse, 0);
    probe(6'd5);
    checkVal("R8 other slice retained", trigLevel, 1);
    checkVal("R6 pulse after new rise", trigPulse, 1);
    probe(6'd37);
    writeWord(3'd2, 16'hFFFF);
    writeWord(3'd4, 16'h0);
    @(negedge clk);
    checkVal("R7 re-armed level", trigLevel, 1);
    checkVal("R7 re-armed pulse", trigPulse, 1);

    // R5: unused addresses neither stage nor commit nor alias
    writeWord(3'd0, 16'h0000);
    writeWord(3'd5, 16'h0000);
    writeWord(3'd6, 16'h0000);
    writeWord(3'd7, 16'h0000);
    probe(6'd3);
    checkVal("R5 unused address did not commit", trigLevel, 1);
    writeWord(3'd4, 16'h0);
    probe(6'd3);
    checkVal("R3 slice 0 staged value", trigLevel, 0);
    probe(6'd20);
    checkVal("R5 addr 5 no alias to slice 1", trigLevel, 1);
    probe(6'd40);
    checkVal("R5 addr 6 no alias to slice 2", trigLevel, 1);
    probe(6'd60);
    checkVal("R5 addr 7 no alias to slice 3", trigLevel, 1);

    // R1/R9: full sweep of every function over all 64 patterns
    for (int f = 0; f < NUM_FUNCS; f++) begin
      loadTable(FUNC_TBL[f]);
      chIn = 6'd0;
      @(negedge clk);
      @(negedge clk);
      prevExp = refEval(f, 6'd0);
      for (int i = 0; i < 64; i++) begin
        chIn = 6'(i);
        @(negedge clk);
        curExp = refEval(f, 6'(i));
        checkVal($sformatf("R1 R9 func%0d idx%0d level", f, i), trigLevel, curExp);
        checkVal($sformatf("R6 func%0d idx%0d pulse", f, i), trigPulse,
                 curExp && !prevExp);
        prevExp = curExp;
      end
    end

    finishRun();
  end

endmodule